// File: doc/BRIEF.md
# Two-Port Memory Access Arbiter with Refresh Timer

This block decides who may use a single DRAM timing sequencer at any moment. There are three contenders: two processor ports (A and B) and an internal refresh timer. The refresh timer divides the system clock by a value set on an input. For example, a factor of five on a 10 MHz clock gives a 2 MHz tick. Ticks that arrive while the memory is in use are stored in a small saturating backlog. Each stored tick later becomes one refresh cycle of fixed length.

A port holds its request high for the whole of its access. It owns the memory from the edge after its grant is issued until the edge after it drops the request. A port that requests but is not granted sees its wait output high. This happens during a refresh, while the other port owns the memory, and while the sequencer reports that the bank still needs precharge. Refresh work that is pending wins over new port requests, but it never cuts short an access already under way. When both ports ask at once from idle, the grant alternates between them.

Top module: `dram_port_arbiter`

## Requirements
- R1: After a synchronous reset, `a_gnt`, `b_gnt` and `ref_busy` are low, and both wait outputs are low while no port requests.
- R2: `ref_tick` is a one-cycle pulse repeating every `div_sel` clock cycles. A `div_sel` of 0 or 1 makes it pulse every cycle.
- R3: At most one of `a_gnt`, `b_gnt` and `ref_busy` is high in any cycle.
- R4: The memory is idle when no grant and no refresh is active. A request seen at a clock edge while the memory is idle, with nothing blocking it, is granted at that edge. The grant stays high while the request stays high. It falls at the first edge where the request is low, and the memory then stays idle for at least that cycle. A port whose request is low at an edge is never granted at that edge.
- R5: When both ports request together from idle, the port not granted most recently wins. Port A wins the first such contest after reset.
- R6: A port's wait output is high whenever its request is high and its grant is low. This covers refresh in progress, the other port owning the memory, and precharge pending.
- R7: While `pchg_pend` is high, no new grant and no new refresh starts. An access already granted continues.
- R8: When the memory is idle with at least one refresh pending, a refresh starts instead of a port grant. A port that keeps its request high is never interrupted by refresh.
- R9: Each refresh holds `ref_busy` high for exactly `REF_CYCLES` consecutive cycles (default 4).
- R10: Refresh ticks are stored up to `BACKLOG` (default 3), with further ticks dropped. Each stored tick produces exactly one refresh once the memory is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | DIV_W | Refresh clock divide factor |
| pchg_pend | input | 1 | Sequencer reports bank precharge not yet complete |
| a_req | input | 1 | Port A access request, held for the access |
| b_req | input | 1 | Port B access request, held for the access |
| a_gnt | output | 1 | Port A owns the memory |
| b_gnt | output | 1 | Port B owns the memory |
| a_wait | output | 1 | Port A must stall |
| b_wait | output | 1 | Port B must stall |
| ref_busy | output | 1 | Refresh cycle in progress |
| ref_tick | output | 1 | Divided refresh tick pulse |

## Verification
The hardest state to reach from the ports is a full backlog followed by the draining of exactly that many refreshes. The divider keeps adding ticks, so it can hide whether a saturated count drains correctly. The bench holds port A granted with a fast divide factor until more ticks have arrived than the backlog can hold. In the same cycle that it releases the port, it raises the divide factor. It then counts refresh starts, with no new tick able to arrive in that window. Priority of pending refresh over a fresh request is reached the same way, by handing the release of one port to a request from the other.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2,
        OWN_REF  = 2'd3
    } owner_t;

    // Terminal count for the divider; factors 0 and 1 both tick every cycle.
    function automatic int unsigned div_limit(input int unsigned factor);
        return (factor <= 1) ? 0 : factor - 1;
    endfunction

    // Winner of a simultaneous request: the port not served last.
    function automatic owner_t rr_pick(input logic last_was_b);
        return last_was_b ? OWN_A : OWN_B;
    endfunction

endpackage

// File: rtl/arb_refresh_div.sv
module arb_refresh_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    import arb_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = DIV_W'(div_limit(int'(div_sel)));
        tick = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/arb_backlog.sv
module arb_backlog #(
    parameter int BACKLOG = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic take,
    output logic pending
);
    localparam int BW = $clog2(BACKLOG + 1);
    localparam logic [BW-1:0] MAXV = BW'(BACKLOG);

    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (cnt != MAXV) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign pending = (cnt != '0);
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm #(
    parameter int REF_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            a_req,
    input  logic            b_req,
    input  logic            pchg_pend,
    input  logic            ref_pending,
    output logic            ref_start,
    output arb_pkg::owner_t owner
);
    import arb_pkg::*;

    localparam int RC_W = $clog2(REF_CYCLES + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(REF_CYCLES - 1);

    owner_t          owner_n;
    logic            last_b;
    logic [RC_W-1:0] rcnt;

    always_comb begin
        owner_n   = owner;
        ref_start = 1'b0;
        unique case (owner)
            OWN_NONE: begin
                if (!pchg_pend) begin
                    if (ref_pending) begin
                        owner_n   = OWN_REF;
                        ref_start = 1'b1;
                    end else if (a_req && b_req) begin
                        owner_n = rr_pick(last_b);
                    end else if (a_req) begin
                        owner_n = OWN_A;
                    end else if (b_req) begin
                        owner_n = OWN_B;
                    end
                end
            end
            OWN_A:   if (!a_req) owner_n = OWN_NONE;
            OWN_B:   if (!b_req) owner_n = OWN_NONE;
            OWN_REF: if (rcnt == '0) owner_n = OWN_NONE;
            default: owner_n = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner  <= OWN_NONE;
            last_b <= 1'b1;
            rcnt   <= '0;
        end else begin
            owner <= owner_n;
            if (owner == OWN_NONE && owner_n == OWN_A) last_b <= 1'b0;
            if (owner == OWN_NONE && owner_n == OWN_B) last_b <= 1'b1;
            if (ref_start)                             rcnt <= RC_LAST;
            else if (owner == OWN_REF && rcnt != '0)   rcnt <= rcnt - 1'b1;
        end
    end
endmodule

// File: rtl/dram_port_arbiter.sv
module dram_port_arbiter #(
    parameter int DIV_W      = 8,
    parameter int REF_CYCLES = 4,
    parameter int BACKLOG    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             pchg_pend,
    input  logic             a_req,
    input  logic             b_req,
    output logic             a_gnt,
    output logic             b_gnt,
    output logic             a_wait,
    output logic             b_wait,
    output logic             ref_busy,
    output logic             ref_tick
);
    import arb_pkg::*;

    logic   pending;
    logic   ref_start;
    owner_t owner;

    arb_refresh_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .div_sel(div_sel), .tick(ref_tick)
    );

    arb_backlog #(.BACKLOG(BACKLOG)) u_backlog (
        .clk(clk), .rst(rst), .tick(ref_tick), .take(ref_start), .pending(pending)
    );

    arb_owner_fsm #(.REF_CYCLES(REF_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .a_req(a_req), .b_req(b_req),
        .pchg_pend(pchg_pend), .ref_pending(pending),
        .ref_start(ref_start), .owner(owner)
    );

    assign a_gnt    = (owner == OWN_A);
    assign b_gnt    = (owner == OWN_B);
    assign ref_busy = (owner == OWN_REF);
    assign a_wait   = a_req && !a_gnt;
    assign b_wait   = b_req && !b_gnt;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_sel,
    input logic             pchg_pend,
    input logic             a_req,
    input logic             b_req,
    input logic             a_gnt,
    input logic             b_gnt,
    input logic             a_wait,
    input logic             b_wait,
    input logic             ref_busy,
    input logic             ref_tick
);
    p_one_owner_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_gnt, b_gnt, ref_busy}));

    p_hold_a_r4: assert property (@(posedge clk) disable iff (rst)
        (a_gnt && a_req) |=> a_gnt);

    p_hold_b_r4: assert property (@(posedge clk) disable iff (rst)
        (b_gnt && b_req) |=> b_gnt);

    p_no_req_no_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        !a_req |=> !a_gnt);

    p_wait_a_r6: assert property (@(posedge clk) disable iff (rst)
        (a_req && !a_gnt) |-> a_wait);

    p_wait_b_r6: assert property (@(posedge clk) disable iff (rst)
        (b_req && !b_gnt) |-> b_wait);

    p_pchg_block_r7: assert property (@(posedge clk) disable iff (rst)
        (!a_gnt && !b_gnt && !ref_busy && pchg_pend) |=> (!a_gnt && !b_gnt && !ref_busy));

    p_no_preempt_r8: assert property (@(posedge clk) disable iff (rst)
        (a_gnt && a_req) |=> !ref_busy);

    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && div_sel > 1 && $stable(div_sel)) |=> !ref_tick);
endmodule

bind dram_port_arbiter arb_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/dram_port_arbiter_test.sv
module dram_port_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_sel = 8'd255;
    logic       pchg_pend = 1'b0, a_req = 1'b0, b_req = 1'b0;
    logic       a_gnt, b_gnt, a_wait, b_wait, ref_busy, ref_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dram_port_arbiter uut (.*);

    always #4 clk = ~clk;

    // {a_req, b_req, pchg, exp a_gnt, exp b_gnt, exp a_wait, exp b_wait}
    localparam logic [6:0] VEC [15] = '{
        7'b000_0000, 7'b110_1001, 7'b110_1001, 7'b010_0001,
        7'b110_0110, 7'b000_0000, 7'b110_1001, 7'b001_0000,
        7'b101_0010, 7'b101_0010, 7'b100_1000, 7'b101_1000,
        7'b000_0000, 7'b010_0100, 7'b000_0000
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] d);
        @(negedge clk);
        rst = 1'b1; a_req = 1'b0; b_req = 1'b0; pchg_pend = 1'b0; div_sel = d;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int first, gap, rises;
        logic prev;

        // R1 reset state
        do_reset(8'd255);
        check("R1 a_gnt", a_gnt, 0);
        check("R1 b_gnt", b_gnt, 0);
        check("R1 ref_busy", ref_busy, 0);
        check("R1 waits", {a_wait, b_wait}, 0);

        // R4 R5 R6 R7: vector walk (no refresh tick inside this window)
        for (int i = 0; i < 15; i++) begin
            {a_req, b_req, pchg_pend} = VEC[i][6:4];
            @(posedge clk); #1;
            check($sformatf("R4/R5 grants step %0d", i), {a_gnt, b_gnt}, VEC[i][3:2]);
            check($sformatf("R6/R7 waits step %0d", i), {a_wait, b_wait}, VEC[i][1:0]);
            @(negedge clk);
        end

        // R2 divider period 5
        do_reset(8'd5);
        first = -1; gap = 0;
        for (int c = 0; c < 30 && gap == 0; c++) begin
            @(negedge clk);
            if (ref_tick) begin
                if (first >= 0) gap = c - first;
                first = c;
            end
        end
        check("R2 tick period div5", gap, 5);
        // R2 divide factor 1 ticks each cycle
        div_sel = 8'd1;
        @(negedge clk); @(negedge clk);
        rises = 0;
        for (int c = 0; c < 6; c++) begin @(negedge clk); rises += int'(ref_tick); end
        check("R2 tick every cycle div1", rises, 6);

        // R9 refresh length and R6 wait during refresh
        do_reset(8'd5);
        prev = 1'b0;
        for (int c = 0; c < 20 && !ref_busy; c++) @(negedge clk);
        a_req = 1'b1;
        @(posedge clk); #1;
        check("R6 a_wait during refresh", a_wait, 1);
        check("R8 no grant during refresh", a_gnt, 0);
        div_sel = 8'd255;
        rises = 1;
        @(negedge clk);
        while (ref_busy && rises < 10) begin rises++; @(negedge clk); end
        check("R9 refresh length", rises, 4);
        for (int c = 0; c < 6 && !a_gnt; c++) @(negedge clk);
        check("R4 grant after refresh", a_gnt, 1);

        // R8 pending refresh wins over new request; no preemption
        do_reset(8'd5);
        a_req = 1'b1;
        repeat (14) @(negedge clk);
        check("R8 held access not preempted", {a_gnt, ref_busy}, 2);
        a_req = 1'b0; b_req = 1'b1;
        @(posedge clk); #1;
        check("R4 idle after release", {a_gnt, b_gnt}, 0);
        @(negedge clk);
        @(posedge clk); #1;
        check("R8 refresh wins", ref_busy, 1);
        check("R6 b_wait during refresh", b_wait, 1);
        b_req = 1'b0; div_sel = 8'd255;
        repeat (20) @(negedge clk);

        // R10 backlog saturation
        do_reset(8'd5);
        a_req = 1'b1;
        repeat (40) @(negedge clk);
        a_req = 1'b0; div_sel = 8'd255;
        rises = 0; prev = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (ref_busy && !prev) rises++;
            prev = ref_busy;
        end
        check("R10 backlog drains to limit", rises, 3);

        // R3 exclusivity under contention with refresh running
        do_reset(8'd3);
        a_req = 1'b1; b_req = 1'b1;
        rises = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (int'(a_gnt) + int'(b_gnt) + int'(ref_busy) > 1) rises++;
            if (c % 7 == 6) a_req = ~a_req;
        end
        check("R3 single owner", rises, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule